// File: doc/BRIEF.md
# Flash Command Register Controller

This block is the command front end of a byte-wide NOR-style flash. It watches host bus writes, turns them into a command register, and from that register decides what a host read returns and when the cell array must erase or program. A read returns array data at the bus address, the maker and device identifier bytes, or the array byte at an address held for verification. Write enable, chip enable and output enable are sampled on the block clock, so they are assumed to be already synchronised to it. A write takes effect on the clock where write enable is seen going high while chip enable is low.

Commands are accepted only while the high programming voltage is reported present. Erase and program each need a set-up write and then a second write that confirms the operation. The confirming write fires a one-clock strobe to the array. The write address is captured when write enable falls and the write data when it rises.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While `vpp_hi_i` is low, the mode is read array, every write is ignored, and neither strobe fires. The same holds from reset.
- R2: The write address is the value of `addr_i` at the clock where `we_ni` is first seen low with `ce_ni` low. The write data is `data_i` at the clock where `we_ni` is first seen high again with `ce_ni` low. A write done with `ce_ni` high has no effect.
- R3: In read-array mode, with `ce_ni` and `oe_ni` both low, `rdata_o` equals `array_rdata_i` and `array_addr_o` equals `addr_i`. With either enable high, `rdata_o` is 00h.
- R4: After command 90h, a read at address 0 gives 89h, a read at address 1 gives B4h, and a read at any other address gives 00h.
- R5: The write pair 20h, 20h asserts `erase_o` for exactly one clock after the second write.
- R6: After the set-up byte 20h, a second write of any other byte aborts the erase. No strobe fires and the mode returns to read array.
- R7: After the set-up byte 40h, the next write programs. `prog_o` is high for one clock, and `prog_addr_o` and `prog_data_o` hold that write's address and data until the next program.
- R8: Command A0h latches its write address. Until the next command, reads return the array byte at that address, whatever `addr_i` is.
- R9: Command C0h makes reads return the array byte at the last programmed address.
- R10: A write of FFh arms a reset, and the mode reads array. A second FFh returns the block to read array. Any other byte after the first FFh is decoded as a fresh command.
- R11: Any byte other than 00h, 20h, 40h, 90h, A0h, C0h and FFh selects read array.
- R12: `erase_o` and `prog_o` are never high together, and neither stays high for two clocks in a row.
- R13: If `vpp_hi_i` drops in the same clock as a confirming write, the write is ignored, no strobe fires, and the mode is read array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| vpp_hi_i | input | 1 | High programming voltage present |
| addr_i | input | ADDR_W | Host byte address |
| data_i | input | 8 | Host write data |
| array_rdata_i | input | 8 | Byte read from the cell array at `array_addr_o` |
| rdata_o | output | 8 | Host read data |
| array_addr_o | output | ADDR_W | Address presented to the cell array for reads |
| erase_o | output | 1 | One-clock erase start strobe |
| prog_o | output | 1 | One-clock program start strobe |
| prog_addr_o | output | ADDR_W | Address of the byte to program |
| prog_data_o | output | 8 | Byte to program |

## Verification
Loss of programming voltage and a confirming erase write can land on the same clock edge. The voltage check must win, so the erase never starts. The bench provokes this by dropping `vpp_hi_i` on the same clock as the rising write enable of the second 20h. It then judges that `erase_o` stays low and that a following read returns array data. A second collision is the address and data changing between the two write enable edges: every bench write drives different values on each edge. Each command is then judged by whether the fall-time address and the rise-time data took effect.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    M_READ, M_ID, M_ERS_SETUP, M_ERS_VFY, M_PGM_SETUP, M_PGM_VFY, M_RST_ARM
  } mode_e;

  localparam logic [7:0] OP_READ    = 8'h00;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_ERS     = 8'h20;
  localparam logic [7:0] OP_ERS_VFY = 8'hA0;
  localparam logic [7:0] OP_PGM     = 8'h40;
  localparam logic [7:0] OP_PGM_VFY = 8'hC0;
  localparam logic [7:0] OP_RESET   = 8'hFF;
endpackage

// File: rtl/flash_we_sync.sv
module flash_we_sync #(
  parameter int ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o
);
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_fall, we_rise;

  assign we_fall = we_q & ~we_ni & ~ce_ni;
  assign we_rise = ~we_q & we_ni & ~ce_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b1;
      addr_q <= '0;
    end else begin
      we_q <= we_ni;
      if (we_fall) addr_q <= addr_i;
    end
  end

  assign wr_stb_o  = we_rise;
  assign wr_addr_o = addr_q;
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vpp_hi_i,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output mode_e             mode_o,
  output logic [ADDR_W-1:0] vfy_addr_o,
  output logic [ADDR_W-1:0] pgm_addr_o,
  output logic [7:0]        pgm_data_o,
  output logic              erase_o,
  output logic              prog_o
);
  mode_e             mode_q, mode_d, dec;
  logic [ADDR_W-1:0] vfy_q, vfy_d, pgm_addr_q, pgm_addr_d;
  logic [7:0]        pgm_data_q, pgm_data_d;
  logic              erase_d, prog_d;

  always_comb begin
    unique case (wr_data_i)
      OP_IDENT:   dec = M_ID;
      OP_ERS:     dec = M_ERS_SETUP;
      OP_ERS_VFY: dec = M_ERS_VFY;
      OP_PGM:     dec = M_PGM_SETUP;
      OP_PGM_VFY: dec = M_PGM_VFY;
      OP_RESET:   dec = M_RST_ARM;
      default:    dec = M_READ;
    endcase
  end

  always_comb begin
    mode_d     = mode_q;
    vfy_d      = vfy_q;
    pgm_addr_d = pgm_addr_q;
    pgm_data_d = pgm_data_q;
    erase_d    = 1'b0;
    prog_d     = 1'b0;
    if (!vpp_hi_i) begin
      mode_d = M_READ;
    end else if (wr_stb_i) begin
      case (mode_q)
        M_ERS_SETUP: begin
          erase_d = (wr_data_i == OP_ERS);
          mode_d  = M_READ;
        end
        M_PGM_SETUP: begin
          prog_d     = 1'b1;
          pgm_addr_d = wr_addr_i;
          pgm_data_d = wr_data_i;
          mode_d     = M_READ;
        end
        M_RST_ARM: mode_d = (wr_data_i == OP_RESET) ? M_READ : dec;
        default:   mode_d = dec;
      endcase
      if (mode_d == M_ERS_VFY) vfy_d = wr_addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= M_READ;
      vfy_q      <= '0;
      pgm_addr_q <= '0;
      pgm_data_q <= '0;
      erase_o    <= 1'b0;
      prog_o     <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      vfy_q      <= vfy_d;
      pgm_addr_q <= pgm_addr_d;
      pgm_data_q <= pgm_data_d;
      erase_o    <= erase_d;
      prog_o     <= prog_d;
    end
  end

  assign mode_o     = mode_q;
  assign vfy_addr_o = vfy_q;
  assign pgm_addr_o = pgm_addr_q;
  assign pgm_data_o = pgm_data_q;
endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W   = 17,
  parameter logic [7:0] MFR_CODE = 8'h89,
  parameter logic [7:0] DEV_CODE = 8'hB4
) (
  input  mode_e             mode_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] vfy_addr_i,
  input  logic [ADDR_W-1:0] pgm_addr_i,
  input  logic [7:0]        array_rdata_i,
  output logic [ADDR_W-1:0] array_addr_o,
  output logic [7:0]        rdata_o
);
  localparam logic [ADDR_W-1:0] ID_MFR_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ID_DEV_ADDR = ADDR_W'(1);

  logic [7:0] id_byte;

  always_comb begin
    case (mode_i)
      M_ERS_VFY: array_addr_o = vfy_addr_i;
      M_PGM_VFY: array_addr_o = pgm_addr_i;
      default:   array_addr_o = addr_i;
    endcase
  end

  always_comb begin
    if (addr_i == ID_MFR_ADDR)      id_byte = MFR_CODE;
    else if (addr_i == ID_DEV_ADDR) id_byte = DEV_CODE;
    else                            id_byte = 8'h00;
  end

  always_comb begin
    if (ce_ni || oe_ni)       rdata_o = 8'h00;
    else if (mode_i == M_ID)  rdata_o = id_byte;
    else                      rdata_o = array_rdata_i;
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W   = 17,
  parameter logic [7:0] MFR_CODE = 8'h89,
  parameter logic [7:0] DEV_CODE = 8'hB4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              vpp_hi_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic [7:0]        array_rdata_i,
  output logic [7:0]        rdata_o,
  output logic [ADDR_W-1:0] array_addr_o,
  output logic              erase_o,
  output logic              prog_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [7:0]        prog_data_o
);
  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr, vfy_addr;
  mode_e             mode;

  flash_we_sync #(.ADDR_W(ADDR_W)) u_we (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_ni    (ce_ni),
    .we_ni    (we_ni),
    .addr_i   (addr_i),
    .wr_stb_o (wr_stb),
    .wr_addr_o(wr_addr)
  );

  flash_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vpp_hi_i  (vpp_hi_i),
    .wr_stb_i  (wr_stb),
    .wr_addr_i (wr_addr),
    .wr_data_i (data_i),
    .mode_o    (mode),
    .vfy_addr_o(vfy_addr),
    .pgm_addr_o(prog_addr_o),
    .pgm_data_o(prog_data_o),
    .erase_o   (erase_o),
    .prog_o    (prog_o)
  );

  flash_read_mux #(.ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rd (
    .mode_i       (mode),
    .ce_ni        (ce_ni),
    .oe_ni        (oe_ni),
    .addr_i       (addr_i),
    .vfy_addr_i   (vfy_addr),
    .pgm_addr_i   (prog_addr_o),
    .array_rdata_i(array_rdata_i),
    .array_addr_o (array_addr_o),
    .rdata_o      (rdata_o)
  );
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ce_ni,
  input logic       we_ni,
  input logic       vpp_hi_i,
  input logic [7:0] data_i,
  input logic       erase_o,
  input logic       prog_o,
  input logic [7:0] prog_data_o
);
  assert_strobe_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(erase_o && prog_o));

  assert_erase_single_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_o |=> !erase_o);

  assert_prog_single_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_o |=> !prog_o);

  assert_no_strobe_vpp_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vpp_hi_i |=> !erase_o && !prog_o);

  assert_erase_confirm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_o |-> $past(data_i) == 8'h20 && $past(we_ni) && !$past(we_ni, 2) && !$past(ce_ni));

  assert_prog_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_o |-> prog_data_o == $past(data_i) && $past(we_ni) && !$past(ce_ni));

  assert_prog_data_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_o |-> $stable(prog_data_o));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (.*);

// File: tb/flash_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, vpp = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    data = '0;
  logic [7:0]    arr_rdata, rdata, prog_data;
  logic [AW-1:0] arr_addr, prog_addr;
  logic          erase, prog;

  int n_vec = 0, n_bad = 0;
  logic [AW-1:0] exp_pgm_addr = '0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] arr_f(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {7'b0, a[16]} ^ 8'h3C;
  endfunction

  assign arr_rdata = arr_f(arr_addr);

  flash_cmd_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .vpp_hi_i(vpp), .addr_i(addr), .data_i(data), .array_rdata_i(arr_rdata),
    .rdata_o(rdata), .array_addr_o(arr_addr), .erase_o(erase), .prog_o(prog),
    .prog_addr_o(prog_addr), .prog_data_o(prog_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // fall edge: address a, data ~d; rise edge: address ~a, data d
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                    input bit drop_vpp = 0, input bit no_ce = 0);
    @(negedge clk); ce_n = no_ce; we_n = 1'b0; addr = a; data = ~d;
    @(negedge clk); we_n = 1'b1; addr = ~a; data = d;
    if (drop_vpp) vpp = 1'b0;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic strobes(input string req, input logic e, input logic p);
    check({req, " erase"}, 32'(erase), 32'(e));
    check({req, " prog"}, 32'(prog), 32'(p));
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
    #1 check(req, 32'(rdata), 32'(exp));
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  function automatic logic [7:0] sweep_exp(input logic [7:0] c, input logic [AW-1:0] wa,
                                           input logic [AW-1:0] a);
    case (c)
      8'h90:   return (a == 0) ? 8'h89 : (a == 1) ? 8'hB4 : 8'h00;
      8'hA0:   return arr_f(wa);
      8'hC0:   return arr_f(exp_pgm_addr);
      default: return arr_f(a);
    endcase
  endfunction

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [AW-1:0] sw_addr;
    sw_addr = 17'h0_1A5C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    strobes("R1 reset", 1'b0, 1'b0);
    rd("R1 reset read array", 17'h0_0005, arr_f(17'h0_0005));
    // R3: disabled read gives 00h
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; addr = 17'h0_0033;
    #1 check("R3 oe high", 32'(rdata), 32'h0);
    ce_n = 1'b1;

    // R7: program
    wr(17'h0_0000, 8'h40);
    strobes("R7 setup", 1'b0, 1'b0);
    wr(17'h1_0F0F, 8'h6D);
    strobes("R7 confirm", 1'b0, 1'b1);
    check("R7 addr", 32'(prog_addr), 32'(17'h1_0F0F));
    check("R7 data", 32'(prog_data), 32'h6D);
    exp_pgm_addr = 17'h1_0F0F;
    @(negedge clk);
    strobes("R12 prog one clock", 1'b0, 1'b0);
    check("R7 data hold", 32'(prog_data), 32'h6D);

    // R9: program verify
    wr(17'h0_0444, 8'hC0);
    rd("R9 verify", 17'h0_0002, arr_f(17'h1_0F0F));

    // R5: erase
    wr(17'h0, 8'h20);
    strobes("R5 setup", 1'b0, 1'b0);
    wr(17'h0, 8'h20);
    strobes("R5 confirm", 1'b1, 1'b0);
    @(negedge clk);
    strobes("R12 erase one clock", 1'b0, 1'b0);
    rd("R5 after erase read", 17'h0_0000, arr_f(17'h0_0000));

    // R6: erase abort
    wr(17'h0, 8'h20);
    wr(17'h0, 8'h90);
    strobes("R6 abort", 1'b0, 1'b0);
    rd("R6 abort read array", 17'h0_0000, arr_f(17'h0_0000));

    // R8 and R2: fall-time address held for verify
    wr(17'h0_0777, 8'hA0);
    rd("R8 verify", 17'h1_5555, arr_f(17'h0_0777));
    rd("R2 fall address", 17'h0_0000, arr_f(17'h0_0777));

    // R4: identifier codes
    wr(17'h0, 8'h90);
    rd("R4 mfr", 17'h0_0000, 8'h89);
    rd("R4 dev", 17'h0_0001, 8'hB4);
    rd("R4 other", 17'h0_0002, 8'h00);

    // R10: reset sequence
    wr(17'h0, 8'hFF);
    rd("R10 armed read", 17'h0_0000, arr_f(17'h0_0000));
    wr(17'h0, 8'h90);
    rd("R10 decode after arm", 17'h0_0000, 8'h89);
    wr(17'h0, 8'hFF);
    wr(17'h0, 8'hFF);
    rd("R10 reset done", 17'h0_0001, arr_f(17'h0_0001));

    // R2: write with chip enable high ignored
    wr(17'h0, 8'h90, 0, 1);
    rd("R2 ce high ignored", 17'h0_0000, arr_f(17'h0_0000));

    // R1: voltage low
    wr(17'h0, 8'h90);
    @(negedge clk); vpp = 1'b0;
    rd("R1 vpp drop forces read", 17'h0_0000, arr_f(17'h0_0000));
    wr(17'h0, 8'h90);
    rd("R1 write ignored", 17'h0_0001, arr_f(17'h0_0001));
    @(negedge clk); vpp = 1'b1;
    wr(17'h0, 8'h40);
    @(negedge clk); vpp = 1'b0;
    wr(17'h0_0100, 8'h11);
    strobes("R1 no program", 1'b0, 1'b0);
    check("R1 prog data kept", 32'(prog_data), 32'h6D);
    @(negedge clk); vpp = 1'b1;

    // R13: vpp drop on the confirm edge
    wr(17'h0, 8'h20);
    wr(17'h0, 8'h20, 1);
    strobes("R13 collision", 1'b0, 1'b0);
    @(negedge clk);
    strobes("R13 collision next", 1'b0, 1'b0);
    vpp = 1'b1;
    rd("R13 read array", 17'h0_0001, arr_f(17'h0_0001));
    wr(17'h0, 8'h20);
    strobes("R13 fresh setup", 1'b0, 1'b0);
    wr(17'h0, 8'h20);
    strobes("R13 fresh erase", 1'b1, 1'b0);

    // R3 R4 R8 R9 R11 R12: sweep every command byte except program set-up
    for (int c = 0; c < 256; c++) begin
      if (c == 8'h40) continue;
      wr(sw_addr, 8'(c));
      strobes("R12 sweep", 1'b0, 1'b0);
      rd("R11 sweep a0", 17'h0_0000, sweep_exp(8'(c), sw_addr, 17'h0_0000));
      rd("R11 sweep a1", 17'h0_0001, sweep_exp(8'(c), sw_addr, 17'h0_0001));
      rd("R3 sweep ax", 17'h1_2222, sweep_exp(8'(c), sw_addr, 17'h1_2222));
      wr(17'h0, 8'hFF);
      wr(17'h0, 8'hFF);
      strobes("R12 sweep reset", 1'b0, 1'b0);
    end

    finish_run();
  end
endmodule